// File: doc/BRIEF.md
# Six-Sector Three-Phase Vector Quantizer

This block turns a two-dimensional error vector, given as signed alpha and beta components from a pair of loop integrators, into one of six unit-magnitude representative vectors. The plane around the origin is cut into six equal 60-degree sectors, and each representative vector points through the middle of its own sector. Every input vector that lands in a sector is replaced by that sector's representative. The block then outputs the on/off state of the three half-bridge legs that produce that vector, so a three-leg power stage can be driven directly.

The sector is chosen from three sign tests and never from an angle computation. The tests are the sign of alpha and the signs of alpha ± sqrt(3)·beta, with sqrt(3) held as a fixed-point constant. The registered result appears one clock after an input strobe. Along with the leg states, the block gives the alpha and beta components of the chosen unit vector, so that the surrounding modulator can subtract them in its feedback path.

Top module: `hexvq`

## Requirements
- R1: Let K = 28378 (sqrt(3) scaled by 2^14), u = alpha·16384 − K·beta and v = alpha·16384 + K·beta. Sector 0, centred at 0°, is chosen when u ≥ 0 and v ≥ 0. This includes the zero vector.
- R2: When v ≥ 0 and u < 0, the sector is 1 (centred at 60°) if alpha ≥ 0, else sector 2 (centred at 120°). A vector on the positive beta axis therefore goes to sector 1.
- R3: When v < 0, the sector is 3 (centred at 180°) if u ≤ 0. Otherwise it is sector 4 (centred at 240°) if alpha ≤ 0, and sector 5 (centred at 300°) if not. The negative alpha axis goes to sector 3 and the negative beta axis to sector 4.
- R4: out_legs holds leg A in bit 2, leg B in bit 1 and leg C in bit 0. The patterns for sectors 0..5 are 100, 110, 010, 011, 001 and 101. Exactly one or two legs are ever high.
- R5: out_ua/out_ub are the unit vector in Q2.14 format (1.0 = 16384, 0.5 = 8192, sqrt(3)/2 = 14189). The values for sectors 0..5 are (16384,0), (8192,14189), (−8192,14189), (−16384,0), (−8192,−14189) and (8192,−14189).
- R6: out_valid is high in the cycle after each cycle with in_valid high, and low otherwise.
- R7: While in_valid is low, out_sector, out_legs, out_ua and out_ub keep their values, whatever alpha and beta do.
- R8: After synchronous reset, out_valid is 0, out_sector is 0, out_legs is 100, out_ua is 16384 and out_ub is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector strobe |
| in_alpha | input | IN_W (16) | Signed alpha component |
| in_beta | input | IN_W (16) | Signed beta component |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_legs | output | 3 | Half-bridge leg states {A,B,C} |
| out_sector | output | 3 | Selected sector index 0..5 |
| out_ua | output | UNIT_W (16) | Alpha component of the selected unit vector |
| out_ub | output | UNIT_W (16) | Beta component of the selected unit vector |

## Verification
On every cycle, the assertions check the one-cycle strobe timing, the holding of results while no strobe arrives, and the legal leg patterns (never all-on or all-off). They also check that the unit-vector outputs agree with the leg pattern, and the tie rules on the axes and at the origin. The bench's scenarios are needed to show that the sector is correct across the whole plane. These scenarios cover the six sector centres, full-scale corners, vectors close to the 30° boundary where the fixed-point constant decides, and a long pseudo-random stream with both back-to-back and gapped strobes.

// File: rtl/vq_pkg.sv
package vq_pkg;

    typedef enum logic [2:0] {
        SEC0 = 3'd0,
        SEC1 = 3'd1,
        SEC2 = 3'd2,
        SEC3 = 3'd3,
        SEC4 = 3'd4,
        SEC5 = 3'd5
    } sector_t;

    // Leg pattern {A,B,C} for a sector; neighbouring sectors differ in one leg.
    function automatic logic [2:0] leg_pattern(input sector_t s);
        case (s)
            SEC0:    return 3'b100;
            SEC1:    return 3'b110;
            SEC2:    return 3'b010;
            SEC3:    return 3'b011;
            SEC4:    return 3'b001;
            SEC5:    return 3'b101;
            default: return 3'b100;
        endcase
    endfunction

    // Signs of the three boundary tests, named for readability.
    typedef struct packed {
        logic a_neg;   // alpha < 0
        logic a_pos;   // alpha > 0
        logic u_neg;   // alpha - sqrt3*beta < 0
        logic u_pos;   // alpha - sqrt3*beta > 0
        logic v_neg;   // alpha + sqrt3*beta < 0
    } signs_t;

endpackage

// File: rtl/hexvq_angle.sv
module hexvq_angle #(
    parameter int IN_W = 16,
    parameter int KF   = 14,
    parameter int K    = 28378
) (
    input  logic signed [IN_W-1:0] alpha,
    input  logic signed [IN_W-1:0] beta,
    output vq_pkg::sector_t        sector
);
    import vq_pkg::*;

    localparam int PW = IN_W + KF + 3;
    localparam logic signed [PW-1:0] KS = PW'(K);

    logic signed [PW-1:0] a_ext, b_ext, a_sc, kb, u, v;
    signs_t sg;

    always_comb begin
        a_ext = {{(PW-IN_W){alpha[IN_W-1]}}, alpha};
        b_ext = {{(PW-IN_W){beta[IN_W-1]}}, beta};
        a_sc  = a_ext <<< KF;
        kb    = b_ext * KS;
        u     = a_sc - kb;
        v     = a_sc + kb;

        sg.a_neg = alpha[IN_W-1];
        sg.a_pos = !alpha[IN_W-1] && (alpha != '0);
        sg.u_neg = u[PW-1];
        sg.u_pos = !u[PW-1] && (u != '0);
        sg.v_neg = v[PW-1];
    end

    // Boundary vectors resolve to the lower-numbered neighbour.
    always_comb begin
        if (!sg.u_neg && !sg.v_neg)
            sector = SEC0;
        else if (!sg.v_neg)
            sector = sg.a_neg ? SEC2 : SEC1;
        else if (!sg.u_pos)
            sector = SEC3;
        else
            sector = sg.a_pos ? SEC5 : SEC4;
    end

endmodule

// File: rtl/hexvq_map.sv
module hexvq_map #(
    parameter int UNIT_W  = 16,
    parameter int ONE     = 16384,
    parameter int HALF_R3 = 14189
) (
    input  vq_pkg::sector_t           sector,
    output logic [2:0]                legs,
    output logic signed [UNIT_W-1:0]  ua,
    output logic signed [UNIT_W-1:0]  ub
);
    import vq_pkg::*;

    localparam logic signed [UNIT_W-1:0] P1 = UNIT_W'(ONE);
    localparam logic signed [UNIT_W-1:0] PH = UNIT_W'(ONE / 2);
    localparam logic signed [UNIT_W-1:0] PS = UNIT_W'(HALF_R3);

    always_comb begin
        legs = leg_pattern(sector);
        case (sector)
            SEC0:    begin ua =  P1; ub = '0;  end
            SEC1:    begin ua =  PH; ub =  PS; end
            SEC2:    begin ua = -PH; ub =  PS; end
            SEC3:    begin ua = -P1; ub = '0;  end
            SEC4:    begin ua = -PH; ub = -PS; end
            SEC5:    begin ua =  PH; ub = -PS; end
            default: begin ua =  P1; ub = '0;  end
        endcase
    end

endmodule

// File: rtl/hexvq.sv
module hexvq #(
    parameter int IN_W    = 16,
    parameter int KF      = 14,
    parameter int K       = 28378,
    parameter int UNIT_W  = 16,
    parameter int ONE     = 16384,
    parameter int HALF_R3 = 14189
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_alpha,
    input  logic signed [IN_W-1:0]   in_beta,
    output logic                     out_valid,
    output logic [2:0]               out_legs,
    output logic [2:0]               out_sector,
    output logic signed [UNIT_W-1:0] out_ua,
    output logic signed [UNIT_W-1:0] out_ub
);
    import vq_pkg::*;

    sector_t sec_d, sec_q;
    logic    vld_q;

    hexvq_angle #(.IN_W(IN_W), .KF(KF), .K(K)) u_angle (
        .alpha  (in_alpha),
        .beta   (in_beta),
        .sector (sec_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= SEC0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                sec_q <= sec_d;
        end
    end

    hexvq_map #(.UNIT_W(UNIT_W), .ONE(ONE), .HALF_R3(HALF_R3)) u_map (
        .sector (sec_q),
        .legs   (out_legs),
        .ua     (out_ua),
        .ub     (out_ub)
    );

    assign out_valid  = vld_q;
    assign out_sector = sec_q;

endmodule

// File: rtl/hexvq_chk.sv
module hexvq_chk #(
    parameter int IN_W   = 16,
    parameter int UNIT_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [IN_W-1:0]   in_alpha,
    input logic signed [IN_W-1:0]   in_beta,
    input logic                     out_valid,
    input logic [2:0]               out_legs,
    input logic [2:0]               out_sector,
    input logic signed [UNIT_W-1:0] out_ua,
    input logic signed [UNIT_W-1:0] out_ub
);

    // R6
    strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sector) && $stable(out_legs)
                       && $stable(out_ua) && $stable(out_ub)));

    // R4
    leg_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_legs) == 1) || ($countones(out_legs) == 2));

    // R5
    unit_axis_chk: assert property (@(posedge clk) disable iff (rst)
        (out_legs == 3'b100 || out_legs == 3'b011) |-> (out_ub == '0));

    // R5
    unit_sign_chk: assert property (@(posedge clk) disable iff (rst)
        out_legs[2] |-> (out_ua > 0));

    // R1
    origin_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_alpha == '0 && in_beta == '0) |=> (out_sector == 3'd0));

    // R2
    pos_beta_axis_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_alpha == '0 && in_beta > 0) |=> (out_sector == 3'd1));

    // R3
    neg_alpha_axis_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_beta == '0 && in_alpha < 0) |=> (out_sector == 3'd3));

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sector == 3'd0 && out_legs == 3'b100));

endmodule

bind hexvq hexvq_chk #(.IN_W(IN_W), .UNIT_W(UNIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_alpha   (in_alpha),
    .in_beta    (in_beta),
    .out_valid  (out_valid),
    .out_legs   (out_legs),
    .out_sector (out_sector),
    .out_ua     (out_ua),
    .out_ub     (out_ub)
);

// File: tb/sim_hexvq.sv
module sim_hexvq;

    typedef struct {
        int         sec;
        logic [2:0] legs;
        int         ua;
        int         ub;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_alpha = '0;
    logic signed [15:0] in_beta  = '0;
    logic               out_valid;
    logic [2:0]         out_legs;
    logic [2:0]         out_sector;
    logic signed [15:0] out_ua;
    logic signed [15:0] out_ub;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    hexvq u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_alpha   (in_alpha),
        .in_beta    (in_beta),
        .out_valid  (out_valid),
        .out_legs   (out_legs),
        .out_sector (out_sector),
        .out_ua     (out_ua),
        .out_ub     (out_ub)
    );

    // Expected result from the sector rules R1..R5.
    function automatic exp_t model(input int a, input int b);
        exp_t e;
        longint u, v;
        u = longint'(a) * 16384 - longint'(b) * 28378;
        v = longint'(a) * 16384 + longint'(b) * 28378;
        if (u >= 0 && v >= 0)      e.sec = 0;          // R1
        else if (v >= 0)           e.sec = (a >= 0) ? 1 : 2;   // R2
        else if (u <= 0)           e.sec = 3;          // R3
        else                       e.sec = (a <= 0) ? 4 : 5;
        case (e.sec)
            0: begin e.legs = 3'b100; e.ua =  16384; e.ub =      0; end
            1: begin e.legs = 3'b110; e.ua =   8192; e.ub =  14189; end
            2: begin e.legs = 3'b010; e.ua =  -8192; e.ub =  14189; end
            3: begin e.legs = 3'b011; e.ua = -16384; e.ub =      0; end
            4: begin e.legs = 3'b001; e.ua =  -8192; e.ub = -14189; end
            default: begin e.legs = 3'b101; e.ua = 8192; e.ub = -14189; end
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one strobe, queued expectation.
    task automatic send(input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1;
        in_alpha = 16'(a);
        in_beta  = 16'(b);
        q.push_back(model(a, b));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops one expectation per output strobe.
    always @(posedge clk) begin
        #5;
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R6 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                string sreq;
                e = q.pop_front();
                sreq = (e.sec == 0) ? "R1 sector" : (e.sec <= 2) ? "R2 sector" : "R3 sector";
                check(int'(out_sector) == e.sec, sreq, int'(out_sector), e.sec);
                check(out_legs == e.legs, "R4 legs", int'(out_legs), int'(e.legs));
                check(int'(out_ua) == e.ua && int'(out_ub) == e.ub, "R5 unit",
                      int'(out_ua) * 65536 + int'(out_ub), e.ua * 65536 + e.ub);
            end
        end
    end

    initial begin
        logic [31:0] lfsr;
        exp_t hold_e;

        // R8 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
        check(out_sector == 3'd0, "R8 sector", int'(out_sector), 0);
        check(out_legs == 3'b100, "R8 legs", int'(out_legs), 4);
        check(out_ua == 16'sd16384 && out_ub == 16'sd0, "R8 unit", int'(out_ua), 16384);

        // R1 origin and axes, R2/R3 tie rules
        send(0, 0);
        send(1000, 0);
        send(0, 1000);
        send(-1000, 0);
        send(0, -1000);
        idle(1);
        // Sector centres
        send(500, 866);
        send(-500, 866);
        send(-500, -866);
        send(500, -866);
        idle(2);
        // Full-scale corners
        send(32767, 32767);
        send(-32768, -32768);
        send(-32768, 0);
        send(32767, -32768);
        send(-32768, 32767);
        idle(1);
        // Near 30/150/210/330 degree boundaries
        send(866, 500);
        send(866, 499);
        send(-866, 500);
        send(-866, -500);
        send(866, -500);
        send(866, -501);
        idle(3);

        // R6 single strobe timing, R7 hold against changing inputs
        send(-700, 100);
        hold_e = model(-700, 100);
        @(negedge clk);
        in_valid = 1'b0;
        in_alpha = 16'sd900;
        in_beta  = -16'sd50;
        check(out_valid == 1'b1, "R6 strobe high", int'(out_valid), 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 strobe low", int'(out_valid), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_alpha = 16'(i * 3000 - 5000);
            in_beta  = 16'(7000 - i * 4000);
        end
        check(int'(out_sector) == hold_e.sec, "R7 hold sector", int'(out_sector), hold_e.sec);
        check(out_legs == hold_e.legs, "R7 hold legs", int'(out_legs), int'(hold_e.legs));
        check(int'(out_ua) == hold_e.ua, "R7 hold unit", int'(out_ua), hold_e.ua);

        // Pseudo-random stream with gaps
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            send(int'($signed(lfsr[15:0])), int'($signed(lfsr[31:16])));
            if (lfsr[3:2] == 2'b00) idle(1 + int'(lfsr[5:4]));
        end
        idle(4);
        check(q.size() == 0, "R6 missing strobes", q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule